// File: doc/BRIEF.md
# Network Interface Control/Status Register

This block is the host-facing register front end of a packet network interface. A simple word-indexed host bus reads and writes it. It holds the five command enables and the sticky status flags: receive done, CRC error, a saturating lost-packet count, transmit done and transmit abort. It also drives one level-sensitive interrupt request.

The block keeps no packet data. Reads and writes of the data words, the start command and the clear operations leave the block as single-cycle strobes to separate receive-buffer and transmit-buffer blocks. Those blocks report packet arrival, CRC state, drain, lost packets, completion and abort back as single-cycle event pulses. The node address comes from a configuration input, and all-ones means that no address is assigned.

A command write can carry three self-clearing strobes: a full reset, a receive clear and a transmit clear. They apply in a fixed order: reset first, then receive clear, then transmit clear. The five command enables then load from the same word. A command write also takes precedence over buffer events that arrive in the same cycle.

Top module: `nic_csr`

## Requirements
- R1: After rst_ni deasserts, a status read (word index 0, i.e. byte address bits [3:1] = 0) returns 16'h0080, with only transmit done (bit 7) set, and irq_o is 0.
- R2: A status read returns timer enable (bit 0), loopback (bit 1), spy (bit 2), receive enable (bit 4), transmit enable (bit 5), transmit abort (bit 6), transmit done (bit 7), lost count (bits 12:9), CRC error (bit 14) and receive done (bit 15). Bits 3, 8 and 13 always read 0.
- R3: A command write (word index 0) loads bits 0, 1, 2, 4 and 5 from the written data. The written values of bits 6, 7, 9–12, 14 and 15 are not stored.
- R4: Command bit 13 (reset) sets transmit done, clears receive done, CRC error, lost count and transmit abort, and pulses both rx_clear_o and tx_clear_o in the write cycle.
- R5: Command bit 3 (clear receive) clears receive done, CRC error and lost count, and pulses rx_clear_o.
- R6: Command bit 8 (clear transmit) sets transmit done, clears transmit abort, and pulses tx_clear_o.
- R7: irq_o equals (receive done AND receive enable) OR (transmit done AND transmit enable) evaluated on the status register, delayed by one clock.
- R8: Reads return the node address at index 1, rx_data_i at index 2 (with rx_pop_o high), the receive bit count ((16 × rx_words_i) − 1) mod 4096 at index 3, and the node address at index 5 (with tx_start_o high). Indices 4, 6 and 7 return 0 and raise no strobe.
- R9: A write to index 1 raises tx_push_o with tx_data_o equal to the written word and clears transmit done. Writes to indices 2–7 change no status and raise no strobe.
- R10: rx_packet_i sets receive done, and also sets CRC error when crc_err_i is 1. rx_drained_i clears receive done. tx_sent_i sets transmit done. tx_abort_i sets transmit abort.
- R11: Each lost_i pulse increments the lost count, which saturates at 15.
- R12: A command write is applied after buffer events of the same cycle, so a clear-receive wins over a simultaneous lost_i or rx_packet_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Host byte address; bits [3:1] select the word |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid in the read cycle |
| node_addr_i | input | 16 | Configured node address, all-ones when unassigned |
| rx_data_i | input | 16 | Head word of the receive buffer |
| rx_words_i | input | 9 | Words held in the receive buffer |
| rx_packet_i | input | 1 | Pulse: a packet was loaded into the receive buffer |
| crc_err_i | input | 1 | CRC result qualifying rx_packet_i |
| rx_drained_i | input | 1 | Pulse: last receive word was read |
| lost_i | input | 1 | Pulse: an incoming packet was dropped |
| tx_sent_i | input | 1 | Pulse: transmission completed |
| tx_abort_i | input | 1 | Pulse: transmission aborted |
| rx_pop_o | output | 1 | Strobe: advance receive buffer |
| rx_clear_o | output | 1 | Strobe: empty receive buffer |
| tx_push_o | output | 1 | Strobe: append tx_data_o to the transmit buffer |
| tx_data_o | output | 16 | Word to append |
| tx_start_o | output | 1 | Strobe: begin transmission |
| tx_clear_o | output | 1 | Strobe: empty transmit buffer |
| irq_o | output | 1 | Interrupt request level |

## Verification
Read data and all outgoing strobes are combinational in the access cycle, so the bench samples them 2 ns after driving the access and before the clock edge. Status effects of a write or an event pulse take effect on the edge that ends that cycle and show in the next read. irq_o follows one edge later. The bench therefore checks it one full cycle after the status edge, and once confirms that it still holds the old value at the status edge itself.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int DATA_W = 16;
  localparam int LOST_W = 4;
  localparam int IDX_W  = 3;
  localparam int N_IDX  = 1 << IDX_W;
  localparam int BITCNT_W = 12;

  // command/status bit positions
  localparam int B_TMR_IE  = 0;
  localparam int B_LOOP    = 1;
  localparam int B_SPY     = 2;
  localparam int B_CLR_RX  = 3;
  localparam int B_RX_IE   = 4;
  localparam int B_TX_IE   = 5;
  localparam int B_TX_ABT  = 6;
  localparam int B_TX_DONE = 7;
  localparam int B_CLR_TX  = 8;
  localparam int B_LOST_LO = 9;
  localparam int B_RESET   = 13;
  localparam int B_CRC     = 14;
  localparam int B_RX_DONE = 15;

  // word indices
  localparam int IDX_STATUS = 0;
  localparam int IDX_NODE   = 1;
  localparam int IDX_RXDATA = 2;
  localparam int IDX_BITCNT = 3;
  localparam int IDX_START  = 5;
  localparam int IDX_CMD    = 0;
  localparam int IDX_TXDATA = 1;

  typedef struct packed {
    logic              rxd;
    logic              crc;
    logic [LOST_W-1:0] lost;
    logic              txd;
    logic              txa;
    logic              txie;
    logic              rxie;
    logic              spy;
    logic              loopb;
    logic              tmr_ie;
  } csr_stat_t;

  function automatic logic [DATA_W-1:0] stat_word(csr_stat_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_TMR_IE]  = s.tmr_ie;
    w[B_LOOP]    = s.loopb;
    w[B_SPY]     = s.spy;
    w[B_RX_IE]   = s.rxie;
    w[B_TX_IE]   = s.txie;
    w[B_TX_ABT]  = s.txa;
    w[B_TX_DONE] = s.txd;
    w[B_LOST_LO +: LOST_W] = s.lost;
    w[B_CRC]     = s.crc;
    w[B_RX_DONE] = s.rxd;
    return w;
  endfunction
endpackage

// File: rtl/nic_csr_decode.sv
module nic_csr_decode
  import nic_csr_pkg::*;
(
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_IDX-1:0] rd_sel_o,
  output logic [N_IDX-1:0] wr_sel_o
);
  for (genvar i = 0; i < N_IDX; i++) begin : g_sel
    assign rd_sel_o[i] = rd_i && (idx_i == IDX_W'(i));
    assign wr_sel_o[i] = wr_i && (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/nic_csr_status.sv
module nic_csr_status
  import nic_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_push_i,
  input  logic              rx_packet_i,
  input  logic              crc_err_i,
  input  logic              rx_drained_i,
  input  logic              lost_i,
  input  logic              tx_sent_i,
  input  logic              tx_abort_i,
  output csr_stat_t         stat_o,
  output logic              rx_clear_o,
  output logic              tx_clear_o
);
  csr_stat_t stat_q, stat_d;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[15:14], wdata_i[12:9], wdata_i[7:6]};

  always_comb begin
    stat_d     = stat_q;
    rx_clear_o = 1'b0;
    tx_clear_o = 1'b0;
    // buffer events first
    if (tx_push_i)   stat_d.txd = 1'b0;
    if (tx_sent_i)   stat_d.txd = 1'b1;
    if (tx_abort_i)  stat_d.txa = 1'b1;
    if (rx_packet_i) begin
      stat_d.rxd = 1'b1;
      if (crc_err_i) stat_d.crc = 1'b1;
    end
    if (rx_drained_i) stat_d.rxd = 1'b0;
    if (lost_i && (stat_d.lost != {LOST_W{1'b1}}))
      stat_d.lost = stat_d.lost + 1'b1;
    // host command last: reset, clear rx, clear tx, then enables
    if (cmd_we_i) begin
      if (wdata_i[B_RESET]) begin
        stat_d     = '0;
        stat_d.txd = 1'b1;
        rx_clear_o = 1'b1;
        tx_clear_o = 1'b1;
      end
      if (wdata_i[B_CLR_RX]) begin
        stat_d.rxd  = 1'b0;
        stat_d.crc  = 1'b0;
        stat_d.lost = '0;
        rx_clear_o  = 1'b1;
      end
      if (wdata_i[B_CLR_TX]) begin
        stat_d.txd = 1'b1;
        stat_d.txa = 1'b0;
        tx_clear_o = 1'b1;
      end
      stat_d.tmr_ie = wdata_i[B_TMR_IE];
      stat_d.loopb  = wdata_i[B_LOOP];
      stat_d.spy    = wdata_i[B_SPY];
      stat_d.rxie   = wdata_i[B_RX_IE];
      stat_d.txie   = wdata_i[B_TX_IE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      stat_q.txd <= 1'b1;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic rxie_i,
  input  logic txd_i,
  input  logic txie_i,
  output logic irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (rxd_i && rxie_i) || (txd_i && txie_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/nic_csr.sv
module nic_csr
  import nic_csr_pkg::*;
#(
  parameter int WORDS_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [IDX_W:0]     addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [DATA_W-1:0]  node_addr_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  input  logic [WORDS_W-1:0] rx_words_i,
  input  logic               rx_packet_i,
  input  logic               crc_err_i,
  input  logic               rx_drained_i,
  input  logic               lost_i,
  input  logic               tx_sent_i,
  input  logic               tx_abort_i,
  output logic               rx_pop_o,
  output logic               rx_clear_o,
  output logic               tx_push_o,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic               tx_start_o,
  output logic               tx_clear_o,
  output logic               irq_o
);
  localparam int WIDE_W = 32;

  logic [N_IDX-1:0] rd_sel, wr_sel;
  csr_stat_t        stat_q;
  logic [WIDE_W-1:0] bits_wide;
  logic unused_top;

  assign unused_top = ^{addr_i[0], bits_wide[WIDE_W-1:BITCNT_W]};

  nic_csr_decode u_dec (
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .idx_i    (addr_i[IDX_W:1]),
    .rd_sel_o (rd_sel),
    .wr_sel_o (wr_sel)
  );

  nic_csr_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (wr_sel[IDX_CMD]),
    .wdata_i      (wdata_i),
    .tx_push_i    (wr_sel[IDX_TXDATA]),
    .rx_packet_i  (rx_packet_i),
    .crc_err_i    (crc_err_i),
    .rx_drained_i (rx_drained_i),
    .lost_i       (lost_i),
    .tx_sent_i    (tx_sent_i),
    .tx_abort_i   (tx_abort_i),
    .stat_o       (stat_q),
    .rx_clear_o   (rx_clear_o),
    .tx_clear_o   (tx_clear_o)
  );

  nic_csr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (stat_q.rxd),
    .rxie_i (stat_q.rxie),
    .txd_i  (stat_q.txd),
    .txie_i (stat_q.txie),
    .irq_o  (irq_o)
  );

  // bit count = 16*words - 1, modulo 2^BITCNT_W
  assign bits_wide = (WIDE_W'(rx_words_i) << 4) - WIDE_W'(1);

  always_comb begin
    rdata_o = '0;
    if (rd_sel[IDX_STATUS]) rdata_o = stat_word(stat_q);
    if (rd_sel[IDX_NODE])   rdata_o = node_addr_i;
    if (rd_sel[IDX_RXDATA]) rdata_o = rx_data_i;
    if (rd_sel[IDX_BITCNT]) rdata_o = DATA_W'(bits_wide[BITCNT_W-1:0]);
    if (rd_sel[IDX_START])  rdata_o = node_addr_i;
  end

  assign rx_pop_o   = rd_sel[IDX_RXDATA];
  assign tx_start_o = rd_sel[IDX_START];
  assign tx_push_o  = wr_sel[IDX_TXDATA];
  assign tx_data_o  = wdata_i;
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk
  import nic_csr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             w_tmr_i,
  input logic             w_loop_i,
  input logic             w_spy_i,
  input logic             w_clr_rx_i,
  input logic             w_rx_ie_i,
  input logic             w_tx_ie_i,
  input logic             w_clr_tx_i,
  input logic             w_reset_i,
  input csr_stat_t        stat_i,
  input logic             irq_o
);
  logic cmd_we;
  assign cmd_we = wr_i && (idx_i == IDX_W'(IDX_CMD));

  p_cmd_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we |=> (stat_i.tmr_ie == $past(w_tmr_i)) && (stat_i.loopb == $past(w_loop_i)) &&
               (stat_i.spy == $past(w_spy_i)) && (stat_i.rxie == $past(w_rx_ie_i)) &&
               (stat_i.txie == $past(w_tx_ie_i)));

  p_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && w_reset_i && !w_clr_tx_i) |=>
      stat_i.txd && !stat_i.rxd && !stat_i.crc && (stat_i.lost == '0) && !stat_i.txa);

  p_clr_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && w_clr_rx_i) |=> !stat_i.rxd && !stat_i.crc && (stat_i.lost == '0));

  p_clr_tx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && w_clr_tx_i) |=> stat_i.txd && !stat_i.txa);

  p_irq_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((stat_i.rxd && stat_i.rxie) || (stat_i.txd && stat_i.txie)));

  p_lost_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i.lost == {LOST_W{1'b1}}) && !(cmd_we && (w_reset_i || w_clr_rx_i))) |=>
      (stat_i.lost == {LOST_W{1'b1}}));
endmodule

bind nic_csr nic_csr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .idx_i      (addr_i[3:1]),
  .w_tmr_i    (wdata_i[0]),
  .w_loop_i   (wdata_i[1]),
  .w_spy_i    (wdata_i[2]),
  .w_clr_rx_i (wdata_i[3]),
  .w_rx_ie_i  (wdata_i[4]),
  .w_tx_ie_i  (wdata_i[5]),
  .w_clr_tx_i (wdata_i[8]),
  .w_reset_i  (wdata_i[13]),
  .stat_i     (stat_q),
  .irq_o      (irq_o)
);

// File: tb/nic_csr_test.sv
`timescale 1ns/1ps
module nic_csr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, wr = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, node = 16'hFFFF, rx_data = 0;
  logic [8:0] rx_words = 0;
  logic rx_packet = 0, crc = 0, rx_drained = 0, lost = 0, tx_sent = 0, tx_abort = 0;
  logic [15:0] rdata, tx_data;
  logic rx_pop, rx_clear, tx_push, tx_start, tx_clear, irq;

  int checks = 0, errors = 0;
  logic [15:0] rv;
  logic c_rxclr, c_txclr, c_push, c_pop, c_start;
  logic [15:0] c_txdata;

  localparam logic [15:0] RST_B = 16'h2000, CRX_B = 16'h0008, CTX_B = 16'h0100;

  always #10 clk = ~clk;

  nic_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .node_addr_i(node), .rx_data_i(rx_data), .rx_words_i(rx_words),
    .rx_packet_i(rx_packet), .crc_err_i(crc), .rx_drained_i(rx_drained), .lost_i(lost),
    .tx_sent_i(tx_sent), .tx_abort_i(tx_abort), .rx_pop_o(rx_pop), .rx_clear_o(rx_clear),
    .tx_push_o(tx_push), .tx_data_o(tx_data), .tx_start_o(tx_start), .tx_clear_o(tx_clear),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr = 1; addr = 4'(idx << 1); wdata = d;
    #2;
    c_rxclr = rx_clear; c_txclr = tx_clear; c_push = tx_push; c_txdata = tx_data;
    @(negedge clk);
    wr = 0; wdata = 0;
  endtask

  task automatic bus_read(input int idx);
    @(negedge clk);
    rd = 1; addr = 4'(idx << 1);
    #2;
    rv = rdata; c_pop = rx_pop; c_start = tx_start;
    c_rxclr = rx_clear; c_txclr = tx_clear; c_push = tx_push;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic pkt(input logic c);
    @(negedge clk); rx_packet = 1; crc = c;
    @(negedge clk); rx_packet = 0; crc = 0;
  endtask

  task automatic pulse_lost();
    @(negedge clk); lost = 1;
    @(negedge clk); lost = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 irq", {15'b0, irq}, 16'h0);
    bus_read(0);
    chk("R1 status", rv, 16'h0080);

    // R3/R7/R2 sweep of all enable combinations
    for (int v = 0; v < 32; v++) begin
      logic [15:0] cb;
      cb = 16'(v & 7) | 16'(((v >> 3) & 1) << 4) | 16'(((v >> 4) & 1) << 5);
      bus_write(0, RST_B | 16'hD6C0 | cb);
      @(negedge clk);
      chk("R7 irq tx", {15'b0, irq}, {15'b0, cb[5]});
      bus_read(0);
      chk("R3 R2 status", rv, 16'h0080 | cb);
      pkt(v[0]);
      bus_read(0);
      chk("R10 R2 status rx", rv, 16'h8080 | cb | (v[0] ? 16'h4000 : 16'h0));
      chk("R7 irq rx", {15'b0, irq}, {15'b0, cb[4] | cb[5]});
    end

    // R4: dirty state then reset strobe
    bus_write(1, 16'h1111);
    repeat (3) pulse_lost();
    @(negedge clk); tx_abort = 1; @(negedge clk); tx_abort = 0;
    bus_read(0);
    chk("R10 R11 dirty", rv, 16'hC637 & 16'hFF77 | 16'h0040);
    bus_write(0, RST_B | 16'h0010);
    chk("R4 rx_clear", {15'b0, c_rxclr}, 16'h1);
    chk("R4 tx_clear", {15'b0, c_txclr}, 16'h1);
    bus_read(0);
    chk("R4 status", rv, 16'h0090);

    // R11 saturation
    for (int i = 0; i < 20; i++) pulse_lost();
    bus_read(0);
    chk("R11 lost sat", rv, 16'h1E90);

    // R5 clear receive
    pkt(1'b1);
    bus_write(0, CRX_B | 16'h0020);
    chk("R5 rx_clear", {15'b0, c_rxclr}, 16'h1);
    chk("R5 tx_clear idle", {15'b0, c_txclr}, 16'h0);
    bus_read(0);
    chk("R5 status", rv, 16'h00A0);

    // R9 push, R6 clear transmit, R7 lag
    @(negedge clk); tx_abort = 1; @(negedge clk); tx_abort = 0;
    bus_write(1, 16'h1234);
    chk("R9 push", {15'b0, c_push}, 16'h1);
    chk("R9 tx_data", c_txdata, 16'h1234);
    bus_read(0);
    chk("R9 txd cleared", rv, 16'h0060);
    chk("R7 irq off", {15'b0, irq}, 16'h0);
    bus_write(0, CTX_B | 16'h0020);
    chk("R6 tx_clear", {15'b0, c_txclr}, 16'h1);
    chk("R6 rx_clear idle", {15'b0, c_rxclr}, 16'h0);
    chk("R7 irq lag", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R7 irq on", {15'b0, irq}, 16'h1);
    bus_read(0);
    chk("R6 status", rv, 16'h00A0);

    // R10 tx_sent and rx_drained
    bus_write(1, 16'h0001);
    @(negedge clk); tx_sent = 1; @(negedge clk); tx_sent = 0;
    bus_read(0);
    chk("R10 tx_sent", rv, 16'h00A0);
    pkt(1'b0);
    @(negedge clk); rx_drained = 1; @(negedge clk); rx_drained = 0;
    bus_read(0);
    chk("R10 drained", rv, 16'h00A0);

    // R8 read decode
    node = 16'h0ABC; rx_data = 16'h5A5A;
    bus_read(1);
    chk("R8 node", rv, 16'h0ABC);
    bus_read(5);
    chk("R8 start data", rv, 16'h0ABC);
    chk("R8 start strobe", {15'b0, c_start}, 16'h1);
    bus_read(2);
    chk("R8 rx data", rv, 16'h5A5A);
    chk("R8 pop", {15'b0, c_pop}, 16'h1);
    for (int k = 0; k < 8; k++) begin
      int w;
      w = (k == 7) ? 511 : k * 37;
      rx_words = 9'(w);
      bus_read(3);
      chk("R8 bitcount", rv, 16'(((16 * w) - 1) & 4095));
    end
    for (int u = 4; u < 8; u++) begin
      if (u == 5) continue;
      bus_read(u);
      chk("R8 unused rd", rv, 16'h0);
      chk("R8 unused strobes", {11'b0, c_pop, c_start, c_rxclr, c_txclr, c_push}, 16'h0);
    end

    // R9 unused writes
    for (int u = 2; u < 8; u++) begin
      bus_write(u, 16'hFFFF);
      chk("R9 unused wr strobes", {13'b0, c_rxclr, c_txclr, c_push}, 16'h0);
    end
    bus_read(0);
    chk("R9 unused wr status", rv, 16'h00A0);

    // R12 precedence
    pulse_lost();
    @(negedge clk);
    lost = 1; rx_packet = 1; crc = 1;
    wr = 1; addr = 0; wdata = CRX_B | 16'h0010;
    @(negedge clk);
    lost = 0; rx_packet = 0; crc = 0; wr = 0; wdata = 0;
    bus_read(0);
    chk("R12 clear wins", rv, 16'h0090);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule